// File: doc/BRIEF.md
# Programmable Asynchronous Serial Transmitter

This block turns bytes written by a processor into asynchronous NRZ frames on one serial line. A frame has a low start bit, then between one and eight data bits sent least significant bit first, then an optional parity bit and one or two high stop bits. Between frames the line rests high. The bit time comes from a 16-bit divisor, and the character format is set by static control inputs.

A one-character holding register sits in front of the frame shifter. Software writes the next byte while the current frame is still on the line, so consecutive frames follow each other with no idle gap. Two separate flags are provided. One shows that the holding register can take a byte. The other shows that the whole transmit path has drained. The interrupt request follows the first flag, gated by an interrupt enable. A write made while the holding register is occupied is dropped, and a sticky flag records that this happened.

Top module: `ser_tx`

## Requirements
- R1: While no frame is being sent, `ser_out` is 1. Each frame starts with one bit of value 0, and data bits go out least significant bit first.
- R2: The number of data bits is `char_len`+1, so `char_len` = 0 gives 1 bit and `char_len` = 7 gives 8 bits.
- R3: `par_sel` encoding: 2'b01 gives even parity, so the data bits and the parity bit together hold an even number of ones. 2'b10 gives odd parity. 2'b00 and 2'b11 send no parity bit. When present, the parity bit follows the last data bit.
- R4: When `stop2` is 0 the frame ends with one stop bit of value 1. When `stop2` is 1 it ends with two.
- R5: Every bit lasts P clock cycles. P = (`div_val`+1)*8 when `div_val` is nonzero, and P = 16 when `div_val` is 0.
- R6: A `wr_stb` pulse while `buf_rdy` is 1 stores `wr_data`, and `buf_rdy` reads 0 from the next cycle on.
- R7: A stored byte moves into the shifter at a bit boundary once the shifter is free. `buf_rdy` returns to 1 in the same cycle that the start bit appears. A byte stored during a frame begins right after that frame's last stop bit, with no idle time between the two frames.
- R8: `shf_empty` is 1 only when the holding register is free and no frame is in flight. It rises exactly N*P cycles after the start bit of the last frame begins, where N is the number of bits in the frame.
- R9: A `wr_stb` pulse while `buf_rdy` is 0 leaves the held byte and the line unchanged, and it sets `drop_flag`. `drop_flag` stays 1 until reset.
- R10: `irq` is 1 exactly when `buf_rdy` and `irq_en` are both 1.
- R11: While `tx_en` is 0 the line stays at 1 and no stored byte moves into the shifter. Writes are still stored. When `tx_en` goes back to 1, the stored byte is sent.
- R12: After reset `ser_out` = 1, `buf_rdy` = 1, `shf_empty` = 1 and `drop_flag` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tx_en | input | 1 | Transmitter enable |
| irq_en | input | 1 | Interrupt enable |
| div_val | input | 16 | Bit-time divisor |
| char_len | input | 3 | Data bits minus one |
| par_sel | input | 2 | Parity selection |
| stop2 | input | 1 | Two stop bits when 1 |
| wr_stb | input | 1 | Byte write strobe |
| wr_data | input | 8 | Byte to send |
| ser_out | output | 1 | Serial line |
| buf_rdy | output | 1 | Holding register free |
| shf_empty | output | 1 | Whole transmit path idle |
| irq | output | 1 | Interrupt request |
| drop_flag | output | 1 | Sticky: a write was ignored |

## Verification
Two situations are hard to reach from the ports, and both depend on timing within a frame. The first is a hand-over from the holding register to the shifter at the exact tick where a frame's last stop bit ends. The second is a write that lands in the short window in which `buf_rdy` is low. The stimulus writes a second byte in the cycle `buf_rdy` returns, which is the start of the first frame. It then tries one more write in the following cycle, while the register is certainly full. It samples both frames as a single continuous bit stream, so any gap, slip or corrupted byte shows up. Random formats and divisors run alongside directed cases for a zero divisor, a one-bit character, two stop bits and a byte held while the transmitter is disabled.

// File: rtl/ser_tx_pkg.sv
package ser_tx_pkg;
    localparam int SER_DATA_W = 8;
    localparam int SER_LEN_W  = $clog2(SER_DATA_W);

    typedef enum logic [1:0] {
        PAR_NONE = 2'b00,
        PAR_EVEN = 2'b01,
        PAR_ODD  = 2'b10,
        PAR_OFF  = 2'b11
    } par_e;

    typedef struct packed {
        logic [SER_LEN_W-1:0] len_m1;
        par_e                 par;
        logic                 stop2;
    } fmt_t;
endpackage

// File: rtl/ser_tx_baud.sv
module ser_tx_baud #(
    parameter int DIV_W    = 16,
    parameter int OVS      = 8,
    parameter int ZERO_PER = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    localparam int CNT_W = DIV_W + $clog2(OVS) + 1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } bd_t;

    bd_t st_q, st_d;
    logic [CNT_W-1:0] lim;

    always_comb begin
        if (div == '0) lim = CNT_W'(ZERO_PER - 1);
        else           lim = (CNT_W'(div) + CNT_W'(1)) * CNT_W'(OVS) - CNT_W'(1);
        tick = en && (st_q.cnt >= lim);
        st_d = st_q;
        if (!en || tick) st_d.cnt = '0;
        else             st_d.cnt = st_q.cnt + CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // the bit time is never shorter than two cycles
    p_tick_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    p_no_tick_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> !tick);
endmodule

// File: rtl/ser_tx_hold.sv
module ser_tx_hold #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              take,
    output logic              full,
    output logic [DATA_W-1:0] data,
    output logic              drop
);
    typedef struct packed {
        logic              full;
        logic [DATA_W-1:0] data;
        logic              drop;
    } hd_t;

    hd_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (take) st_d.full = 1'b0;
        if (wr_stb) begin
            if (!st_q.full) begin
                st_d.full = 1'b1;
                st_d.data = wr_data;
            end else begin
                st_d.drop = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign full = st_q.full;
    assign data = st_q.data;
    assign drop = st_q.drop;

    p_take_needs_byte_r7: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> st_q.full);
    p_write_stored_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && !st_q.full) |=> (st_q.full && st_q.data == $past(wr_data)));
    p_held_kept_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && st_q.full && !take) |=> (st_q.full && $stable(st_q.data) && st_q.drop));
    p_drop_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.drop |=> st_q.drop);
endmodule

// File: rtl/ser_tx_shift.sv
module ser_tx_shift
    import ser_tx_pkg::*;
#(
    parameter int DATA_W = SER_DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              tick,
    input  fmt_t              fmt,
    input  logic              hold_full,
    input  logic [DATA_W-1:0] hold_data,
    output logic              take,
    output logic              line,
    output logic              busy
);
    localparam int FRAME_W = DATA_W + 4;
    localparam int CNT_W   = $clog2(FRAME_W + 1);

    typedef struct packed {
        logic               busy;
        logic [FRAME_W-1:0] frame;
        logic [CNT_W-1:0]   left;
    } sh_t;

    localparam sh_t IDLE = '{busy: 1'b0, frame: '1, left: '0};

    sh_t st_q, st_d;
    logic [FRAME_W-1:0] ld_frame;
    logic [CNT_W-1:0]   ld_cnt;

    // frame image for the held byte: start, data, parity, stop
    always_comb begin : build
        int   pos;
        logic pbit;
        logic has_par;
        ld_frame    = '1;
        ld_frame[0] = 1'b0;
        pbit        = 1'b0;
        for (int i = 0; i < DATA_W; i++) begin
            if (i <= int'(fmt.len_m1)) begin
                ld_frame[i+1] = hold_data[i];
                pbit          = pbit ^ hold_data[i];
            end
        end
        has_par = (fmt.par == PAR_EVEN) || (fmt.par == PAR_ODD);
        pos     = int'(fmt.len_m1) + 2;
        for (int j = 0; j < FRAME_W; j++) begin
            if (has_par && j == pos) ld_frame[j] = (fmt.par == PAR_ODD) ? ~pbit : pbit;
        end
        ld_cnt = CNT_W'(pos + (has_par ? 1 : 0) + (fmt.stop2 ? 2 : 1));
    end

    assign take = en && tick && hold_full && (!st_q.busy || st_q.left == CNT_W'(1));

    always_comb begin
        st_d = st_q;
        if (!en) begin
            st_d = IDLE;
        end else if (tick) begin
            if (take) begin
                st_d.busy  = 1'b1;
                st_d.frame = ld_frame;
                st_d.left  = ld_cnt;
            end else if (st_q.busy) begin
                if (st_q.left == CNT_W'(1)) begin
                    st_d = IDLE;
                end else begin
                    st_d.frame = {1'b1, st_q.frame[FRAME_W-1:1]};
                    st_d.left  = st_q.left - CNT_W'(1);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= IDLE;
        else        st_q <= st_d;
    end

    assign line = st_q.frame[0];
    assign busy = st_q.busy;

    p_mark_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.busy |-> line);
    p_start_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> (st_q.busy && !line));
    p_steady_bit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !tick) |=> $stable(line));
    p_left_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.busy |-> (st_q.left != '0 && st_q.left <= CNT_W'(FRAME_W)));
    p_off_mark_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> line);
endmodule

// File: rtl/ser_tx.sv
module ser_tx
    import ser_tx_pkg::*;
#(
    parameter int DIV_W    = 16,
    parameter int OVS      = 8,
    parameter int ZERO_PER = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  tx_en,
    input  logic                  irq_en,
    input  logic [DIV_W-1:0]      div_val,
    input  logic [SER_LEN_W-1:0]  char_len,
    input  logic [1:0]            par_sel,
    input  logic                  stop2,
    input  logic                  wr_stb,
    input  logic [SER_DATA_W-1:0] wr_data,
    output logic                  ser_out,
    output logic                  buf_rdy,
    output logic                  shf_empty,
    output logic                  irq,
    output logic                  drop_flag
);
    logic                  tick;
    logic                  take;
    logic                  hold_full;
    logic [SER_DATA_W-1:0] hold_data;
    logic                  busy;
    fmt_t                  fmt;

    assign fmt = '{len_m1: char_len, par: par_e'(par_sel), stop2: stop2};

    ser_tx_baud #(.DIV_W(DIV_W), .OVS(OVS), .ZERO_PER(ZERO_PER)) u_baud (
        .clk(clk), .rst_n(rst_n), .en(tx_en), .div(div_val), .tick(tick)
    );

    ser_tx_hold #(.DATA_W(SER_DATA_W)) u_hold (
        .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_data(wr_data),
        .take(take), .full(hold_full), .data(hold_data), .drop(drop_flag)
    );

    ser_tx_shift #(.DATA_W(SER_DATA_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .en(tx_en), .tick(tick), .fmt(fmt),
        .hold_full(hold_full), .hold_data(hold_data),
        .take(take), .line(ser_out), .busy(busy)
    );

    assign buf_rdy   = !hold_full;
    assign shf_empty = !hold_full && !busy;
    assign irq       = buf_rdy && irq_en;

    p_empty_means_free_r8: assert property (@(posedge clk) disable iff (!rst_n)
        shf_empty |-> buf_rdy);
    p_empty_line_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
        shf_empty |-> ser_out);
    p_disabled_keeps_byte_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_en && !buf_rdy) |=> !buf_rdy);
endmodule

// File: tb/sim_ser_tx.sv
module sim_ser_tx;
    localparam int CLK_T = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tx_en = 1'b0;
    logic        irq_en = 1'b0;
    logic [15:0] div_val = '0;
    logic [2:0]  char_len = 3'd7;
    logic [1:0]  par_sel = 2'b00;
    logic        stop2 = 1'b0;
    logic        wr_stb = 1'b0;
    logic [7:0]  wr_data = '0;
    logic        ser_out, buf_rdy, shf_empty, irq, drop_flag;

    int total = 0;
    int bad = 0;
    bit exp_drop = 1'b0;

    always #(CLK_T/2) clk = ~clk;

    ser_tx u0 (
        .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .irq_en(irq_en),
        .div_val(div_val), .char_len(char_len), .par_sel(par_sel), .stop2(stop2),
        .wr_stb(wr_stb), .wr_data(wr_data), .ser_out(ser_out), .buf_rdy(buf_rdy),
        .shf_empty(shf_empty), .irq(irq), .drop_flag(drop_flag)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int bit_time(input logic [15:0] d);
        return (d == 16'd0) ? 16 : (int'(d) + 1) * 8;
    endfunction

    function automatic int frame_len(input logic [2:0] l, input logic [1:0] p, input logic s2);
        return 1 + int'(l) + 1 + ((p == 2'b01 || p == 2'b10) ? 1 : 0) + (s2 ? 2 : 1);
    endfunction

    function automatic logic [11:0] frame_bits(input logic [7:0] d, input logic [2:0] l,
                                               input logic [1:0] p, input logic s2);
        logic [11:0] f;
        int   k;
        logic x;
        f = '1;
        f[0] = 1'b0;
        x = 1'b0;
        k = 1;
        for (int i = 0; i <= int'(l); i++) begin
            f[k] = d[i];
            x = x ^ d[i];
            k++;
        end
        if (p == 2'b01) f[k] = x;
        if (p == 2'b10) f[k] = ~x;
        return f;
    endfunction

    // send one or two bytes and check the line as one continuous bit stream
    task automatic run(input logic [7:0] d1, input bit w1, input bit two,
                       input logic [7:0] d2, input bit junk);
        int P, n, nb;
        logic [23:0] exp_s;
        logic [11:0] f1, f2;
        P  = bit_time(div_val);
        n  = frame_len(char_len, par_sel, stop2);
        f1 = frame_bits(d1, char_len, par_sel, stop2);
        f2 = frame_bits(d2, char_len, par_sel, stop2);
        exp_s = '1;
        for (int i = 0; i < n; i++) exp_s[i] = f1[i];
        if (two) for (int i = 0; i < n; i++) exp_s[n+i] = f2[i];
        nb = two ? 2 * n : n;
        fork
            begin
                if (w1) begin
                    while (!buf_rdy) @(negedge clk);
                    wr_stb = 1'b1; wr_data = d1;
                    @(negedge clk); wr_stb = 1'b0;
                end
                if (two) begin
                    while (!buf_rdy) @(negedge clk);
                    wr_stb = 1'b1; wr_data = d2;
                    @(negedge clk); wr_stb = 1'b0;
                    if (junk && !buf_rdy) begin
                        wr_stb = 1'b1; wr_data = ~d2;
                        exp_drop = 1'b1;
                        @(negedge clk); wr_stb = 1'b0;
                    end
                end
            end
            begin
                int mism, first;
                mism = 0; first = -1;
                while (ser_out) @(negedge clk);
                chk("R7 buf_rdy at start bit", int'(buf_rdy), 1);
                repeat (P/2) @(negedge clk);
                for (int k = 0; k < nb; k++) begin
                    if (ser_out !== exp_s[k]) begin
                        mism++;
                        if (first < 0) first = k;
                    end
                    if (k < nb - 1) repeat (P) @(negedge clk);
                end
                // R1 R2 R3 R4 R7: start, data order, parity, stop, no gap
                chk("R1/R2/R3/R4/R7 stream mismatches", mism, 0);
                repeat (P/2 - 1) @(negedge clk);
                chk("R8 shf_empty before end", int'(shf_empty), 0);
                @(negedge clk);
                chk("R5/R8 shf_empty at N*P", int'(shf_empty), 1);
                chk("R1 idle mark", int'(ser_out), 1);
            end
        join
        chk("R9 drop_flag", int'(drop_flag), int'(exp_drop));
        chk("R10 irq", int'(irq), int'(irq_en));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int seed_tmp;
        seed_tmp = $urandom(32'd4711);
        irq_en = 1'b1;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R12 ser_out", int'(ser_out), 1);
        chk("R12 buf_rdy", int'(buf_rdy), 1);
        chk("R12 shf_empty", int'(shf_empty), 1);
        chk("R12 drop_flag", int'(drop_flag), 0);
        chk("R10 irq enabled", int'(irq), 1);
        irq_en = 1'b0;
        @(negedge clk);
        chk("R10 irq masked", int'(irq), 0);

        // R11: byte written while disabled must wait
        irq_en = 1'b1;
        wr_stb = 1'b1; wr_data = 8'hA5;
        @(negedge clk); wr_stb = 1'b0;
        begin
            int highs;
            highs = 0;
            for (int i = 0; i < 200; i++) begin
                if (ser_out) highs++;
                @(negedge clk);
            end
            chk("R11 line high while off", highs, 200);
        end
        chk("R6/R11 buf_rdy low with byte held", int'(buf_rdy), 0);
        chk("R8 shf_empty low with byte held", int'(shf_empty), 0);
        chk("R10 irq low while full", int'(irq), 0);
        tx_en = 1'b1;
        run(8'hA5, 1'b0, 1'b0, 8'h00, 1'b0);

        // directed corner cases
        div_val = 16'd0; char_len = 3'd7; par_sel = 2'b00; stop2 = 1'b0;
        run(8'h00, 1'b1, 1'b0, 8'h00, 1'b0);           // R5 zero divisor
        div_val = 16'd1;
        run(8'hFF, 1'b1, 1'b0, 8'h00, 1'b0);           // R5 divisor 1
        div_val = 16'd3; char_len = 3'd0; par_sel = 2'b10; stop2 = 1'b1;
        run(8'h01, 1'b1, 1'b0, 8'h00, 1'b0);           // R2 one bit, R3 odd, R4 two stops
        char_len = 3'd4; par_sel = 2'b01; stop2 = 1'b0;
        run(8'h16, 1'b1, 1'b1, 8'h09, 1'b1);           // R7 back-to-back, R9 drop
        par_sel = 2'b11;
        run(8'h55, 1'b1, 1'b1, 8'hAA, 1'b0);           // R3 no parity via 2'b11

        // random formats, divisors and data
        for (int it = 0; it < 24; it++) begin
            div_val  = 16'($urandom_range(0, 5));
            char_len = 3'($urandom_range(0, 7));
            par_sel  = 2'($urandom_range(0, 3));
            stop2    = 1'($urandom_range(0, 1));
            irq_en   = 1'($urandom_range(0, 1));
            run(8'($urandom), 1'b1, 1'($urandom_range(0, 1)), 8'($urandom),
                1'($urandom_range(0, 1)));
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule